// File: doc/BRIEF.md
# Serial-Bus Control Register with Deferred Disable

This block holds the control state of a two-wire serial bus controller: a peripheral enable, a mode select between plain two-wire operation and system-management-bus operation, and three one-shot requests (start condition, stop condition, packet-error-check). Software writes the register through a simple single-cycle write port and reads it back through a combinational read port. The protocol engine consumes the request outputs, pulses an acknowledge per request once it has acted on it, and reports whether the bus transfer is idle.

Turning the peripheral off is not immediate when a transfer is running. A write that clears the enable while the engine is busy only arms a pending-disable flag. The effective enable stays high until the first cycle the engine reports idle; at that moment the enable drops and the outstanding requests are flushed together. Software can poll the effective enable and the pending flag to see when the shutdown has completed.

Top module: `sbus_ctrl_reg`

## Requirements
- R1: After reset every register bit is zero: the read data is 0 and all request, mode and enable outputs are low.
- R2: A write takes bit 0 as the enable and bit 1 as the mode (0 two-wire, 1 system-management-bus); a write with bit 0 set raises the effective enable on the next cycle, and bit 1 is stored on every write.
- R3: A write with bit 0 clear while the engine reports idle (or while already disabled) drops the effective enable on the next cycle and clears all request bits.
- R4: A write with bit 0 clear while enabled and the engine is busy keeps the effective enable high, keeps the requests, and sets the pending-disable flag (read bit 5).
- R5: While disable is pending, the first cycle with the idle input high clears the enable, the pending flag and all request bits on the following cycle.
- R6: A write with bit 0 set cancels a pending disable; the block then stays enabled when the engine goes idle.
- R7: Request bits are start (bit 2), stop (bit 3) and check (bit 4); a 1 sets a request only in a write whose bit 0 is set, and writing 0 to a request bit never clears it.
- R8: An acknowledge pulse for a request clears that request bit on the next cycle.
- R9: If a write sets a request in the same cycle its acknowledge arrives, the request stays set.
- R10: Read bit 0 shows the effective enable, bit 5 the pending flag; bits 6 and above read zero, and writing bits 5 and above has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Read-back of the register |
| eng_idle | input | 1 | Protocol engine reports the transfer is idle |
| ack_start | input | 1 | Engine has issued the start condition |
| ack_stop | input | 1 | Engine has issued the stop condition |
| ack_pec | input | 1 | Engine has handled the packet-error-check |
| enable_o | output | 1 | Effective peripheral enable |
| smb_mode_o | output | 1 | Mode select, 1 for system-management-bus |
| start_req_o | output | 1 | Pending start request |
| stop_req_o | output | 1 | Pending stop request |
| pec_req_o | output | 1 | Pending check request |

## Verification
The assertions watch, on every cycle, that a busy-time disable write leaves the enable up, that an armed disable completes and flushes the requests one cycle after idle appears, that an acknowledge clears its request, that a same-cycle set beats an acknowledge, and that the pending flag never exists without the enable. What only the bench scenarios show is the full read-back layout over a sequence: mode storage, request writes ignored when bit 0 is clear, a cancelled disable surviving a later idle cycle, and reserved bits that stay zero after being written with ones.

// File: rtl/sbus_ctrl_reg.sv
module sbus_ctrl_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             eng_idle,
  input  logic             ack_start,
  input  logic             ack_stop,
  input  logic             ack_pec,
  output logic             enable_o,
  output logic             smb_mode_o,
  output logic             start_req_o,
  output logic             stop_req_o,
  output logic             pec_req_o
);
  localparam int EN_B   = 0;
  localparam int MODE_B = 1;
  localparam int REQ_LO = 2;
  localparam int NREQ   = 3;
  localparam int PEND_B = REQ_LO + NREQ;

  logic            en_q, pend_q, mode_q;
  logic [NREQ-1:0] req_q, req_ack, req_set;
  logic            wr_on, wr_off, dis_now;

  assign wr_on   = wr_en &&  wr_data[EN_B];
  assign wr_off  = wr_en && !wr_data[EN_B];
  assign dis_now = (wr_off && (!en_q || eng_idle)) || (pend_q && eng_idle && !wr_on);
  assign req_ack = {ack_pec, ack_stop, ack_start};
  assign req_set = wr_on ? wr_data[REQ_LO +: NREQ] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= 1'b0;
      req_q  <= '0;
    end else begin
      if (wr_en) mode_q <= wr_data[MODE_B];
      if (wr_on)        en_q <= 1'b1;
      else if (dis_now) en_q <= 1'b0;
      if (wr_on || dis_now)              pend_q <= 1'b0;
      else if (wr_off && en_q && !eng_idle) pend_q <= 1'b1;
      if (dis_now) req_q <= '0;
      else         req_q <= (req_q & ~req_ack) | req_set;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[EN_B]   = en_q;
    rd_data[MODE_B] = mode_q;
    rd_data[REQ_LO +: NREQ] = req_q;
    rd_data[PEND_B] = pend_q;
  end

  assign enable_o    = en_q;
  assign smb_mode_o  = mode_q;
  assign start_req_o = req_q[0];
  assign stop_req_o  = req_q[1];
  assign pec_req_o   = req_q[2];

  // R4
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !eng_idle && wr_off) |=> (enable_o && pend_q));
  // R5
  idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && eng_idle && !wr_on) |=> (!enable_o && !pend_q && req_q == '0));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req_o && ack_start && !(wr_on && wr_data[REQ_LO])) |=> !start_req_o);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && wr_data[REQ_LO+1] && ack_stop) |=> stop_req_o);
  // R10
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> enable_o);
endmodule

// File: tb/sbus_ctrl_reg_tb.sv
module sbus_ctrl_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         eng_idle = 1'b1;
  logic         ack_start = 1'b0, ack_stop = 1'b0, ack_pec = 1'b0;
  logic         enable_o, smb_mode_o, start_req_o, stop_req_o, pec_req_o;

  typedef struct { logic [W-1:0] rd; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_ctrl_reg #(.REG_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eng_idle(eng_idle), .ack_start(ack_start), .ack_stop(ack_stop), .ack_pec(ack_pec),
    .enable_o(enable_o), .smb_mode_o(smb_mode_o), .start_req_o(start_req_o),
    .stop_req_o(stop_req_o), .pec_req_o(pec_req_o));

  task automatic step(input logic wr, input logic [W-1:0] d, input logic idle,
                      input logic [2:0] acks, input logic [W-1:0] exp_rd, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = wr; wr_data = d; eng_idle = idle;
    {ack_pec, ack_stop, ack_start} = acks;
    @(posedge clk);
    #1;
    e.rd = exp_rd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (rd_data !== e.rd || enable_o !== e.rd[0] || smb_mode_o !== e.rd[1] ||
            {pec_req_o, stop_req_o, start_req_o} !== e.rd[4:2]) begin
          fails++;
          $display("FAIL %s: rd=%02h ports(en,mode,req)=%b%b%b%b%b expected rd=%02h",
                   e.tag, rd_data, enable_o, smb_mode_o, pec_req_o, stop_req_o,
                   start_req_o, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== '0 || enable_o || smb_mode_o || start_req_o || stop_req_o || pec_req_o) begin
      fails++;
      $display("FAIL R1 in reset: rd=%02h expected 00", rd_data);
    end
    rst_n = 1'b1;
    step(0, 8'h00, 1, 3'b000, 8'h00, "R1 after reset");
    step(1, 8'h01, 1, 3'b000, 8'h01, "R2 enable");
    step(1, 8'h03, 1, 3'b000, 8'h03, "R2 mode");
    step(1, 8'h07, 1, 3'b000, 8'h07, "R7 set start");
    step(1, 8'h03, 1, 3'b000, 8'h07, "R7 zero does not clear");
    step(0, 8'h00, 1, 3'b001, 8'h03, "R8 ack start");
    step(1, 8'h09, 1, 3'b000, 8'h09, "R7 set stop");
    step(1, 8'h09, 1, 3'b010, 8'h09, "R9 set beats ack");
    step(1, 8'h11, 0, 3'b000, 8'h19, "R7 set check");
    step(1, 8'h00, 0, 3'b000, 8'h39, "R4 deferred");
    step(0, 8'h00, 0, 3'b000, 8'h39, "R4 still busy");
    step(0, 8'h00, 1, 3'b000, 8'h00, "R5 applied at idle");
    step(1, 8'h05, 1, 3'b000, 8'h05, "R2 re-enable");
    step(1, 8'h00, 0, 3'b000, 8'h25, "R4 pending again");
    step(1, 8'h01, 0, 3'b000, 8'h05, "R6 cancel");
    step(0, 8'h00, 1, 3'b000, 8'h05, "R6 stays on at idle");
    step(1, 8'h1C, 1, 3'b000, 8'h00, "R3 R7 immediate off");
    step(1, 8'hC3, 1, 3'b000, 8'h03, "R10 reserved");
    step(1, 8'h20, 1, 3'b000, 8'h00, "R10 R3 pending not writable");
    step(0, 8'h00, 1, 3'b000, 8'h00, "R3 stays off");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule